// File: doc/BRIEF.md
# Triggered Multi-Mode DMA Channel

One programmable channel of a DMA engine. Software supplies a source address, a destination address, a transfer count, a three-bit mode, an address-step setting and an access width for each side. It then arms the channel with a one-cycle enable pulse. Arming copies the three programmed values into working registers. A transfer begins on a rising edge of the external trigger, on a high trigger level, or on a software request pulse. Each transfer reads one byte or word through a simple synchronous memory port and writes it back to the destination.

While the channel owns the bus it drives a CPU-halt output. In burst-block mode it releases the CPU for a short gap after every few transfers. When the working count runs out, the working registers reload from the programmed values and a sticky interrupt flag is raised. The mode decides whether the channel stays armed and whether the next block needs a new trigger. An NMI can cut a service short, and so can a software disarm pulse. Arbitration between channels and interrupt vectoring belong to the surrounding controller.

Top module: `trig_dma_channel`

## Requirements
- R1: `cfg_mode` selects the mode as follows. 000 is single, 001 is block, 010 and 011 are burst-block, 100 is repeated single, 101 is repeated block, 110 and 111 are repeated burst-block. In the three non-repeated modes `chan_en` falls when the count runs out. In the repeated modes it stays high.
- R2: An `en_set` pulse in the idle state sets `chan_en` and loads the working source, destination and count from `cfg_src`, `cfg_dst` and `cfg_size`. A programmed count of zero produces no memory access at all.
- R3: When the final transfer of a count completes, the working registers reload from the programmed values and `irq_flag` is set. The flag stays set until a `flag_clr` pulse.
- R4: In single modes, each trigger event produces exactly one transfer. A trigger event is a rising edge of `trig_in` (a held-high level counts once) or an `sw_req` pulse. The latched software request clears itself when it is accepted.
- R5: In block and burst-block modes, one trigger event runs the whole block. Edges and `sw_req` pulses that arrive while a block is running are ignored. Repeated block waits for a fresh trigger. Repeated burst-block starts the next block at once without one.
- R6: `cpu_halt` is high during every transfer and for the whole length of a block. In burst-block mode it drops for exactly 2 cycles after every 4th transfer, except after the last transfer of the block.
- R7: Each step field works as follows. 00 and 01 hold the address, 10 decrements it and 11 increments it. The step size is 1 for a byte side (width bit 0) and 2 for a word side (width bit 1).
- R8: Byte reads use `mem_rdata[7:0]`. Byte source to word destination writes the byte with zeros in bits 15:8. Word source to byte destination writes only the low byte, with zeros above. Word to word copies all 16 bits.
- R9: With `cfg_level` set, the channel transfers only while `trig_in` is high. While it is low, the channel stalls between transfers with `cpu_halt` low. It resumes at the next address once the trigger returns high.
- R10: Each transfer takes two cycles. The first cycle asserts `mem_rd` with the source address. The second asserts `mem_wr` with the destination address, using data that arrived on `mem_rdata` in that cycle. At least one cycle with neither strobe follows. Within a block, consecutive writes are exactly 3 cycles apart, apart from burst gaps. `trig_in` passes through two synchronizing flops.
- R11: With `cfg_abort_en` set, an `nmi` pulse lets the transfer in flight finish its write, then clears `chan_en` and sets `abort_flag` (cleared by `flag_clr`). An `en_clr` pulse stops the channel the same way but does not set `abort_flag`.
- R12: After reset, `chan_en`, `cpu_halt`, `irq_flag`, `abort_flag`, `mem_rd` and `mem_wr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 3 | Transfer mode |
| cfg_src_step | input | 2 | Source address step |
| cfg_dst_step | input | 2 | Destination address step |
| cfg_src_word | input | 1 | Source access is a word |
| cfg_dst_word | input | 1 | Destination access is a word |
| cfg_level | input | 1 | Level-sensitive trigger select |
| cfg_abort_en | input | 1 | Allow NMI to abort |
| cfg_src | input | AW | Programmed source address |
| cfg_dst | input | AW | Programmed destination address |
| cfg_size | input | SW | Programmed transfer count |
| en_set | input | 1 | Arm pulse |
| en_clr | input | 1 | Disarm pulse |
| sw_req | input | 1 | Software trigger pulse |
| flag_clr | input | 1 | Clears irq and abort flags |
| trig_in | input | 1 | Asynchronous hardware trigger |
| nmi | input | 1 | Non-maskable interrupt pulse |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_word | output | 1 | Access is a word |
| mem_addr | output | AW | Access address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd` |
| cpu_halt | output | 1 | CPU halt request |
| chan_en | output | 1 | Channel armed |
| irq_flag | output | 1 | Count-complete flag |
| abort_flag | output | 1 | NMI abort flag |

## Verification
The copy path is driven with directed configurations and with seeded random ones that mix block and burst modes, all four step codes, both widths on each side, and counts from one to six. Comparing every read address, write address and write data against a bench model separates increment from decrement from hold, and shows padding apart from truncation. Single mode is driven with a held-high edge and with software pulses, which shows whether one event yields exactly one transfer. Repeated block is given extra triggers in mid-block, and a level trigger is dropped part way through a block. Together these show that the block runs once, stalls in place, and resumes at the right address. Burst mode is timed by counting halt-low cycles, and an NMI is injected during a read to show that the write still completes before the stop.

// File: rtl/trig_dma_pkg.sv
// Shared types and mode decoding for the triggered DMA channel.
// Assumes the mode field layout: bit 2 = repeat, bit 1 = burst, bit 0 = block
// (bit 0 only meaningful when bit 1 is clear).
package trig_dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_GAP  = 2'd3
    } dma_state_e;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    localparam logic [1:0] STEP_DEC = 2'b10;
    localparam logic [1:0] STEP_INC = 2'b11;

    // True when the mode moves one item per trigger
    function automatic logic mode_single(input logic [2:0] m);
        return (m[1:0] == 2'b00);
    endfunction

    // True for burst-block variants
    function automatic logic mode_burst(input logic [2:0] m);
        return m[1];
    endfunction

    // True for repeated variants
    function automatic logic mode_repeat(input logic [2:0] m);
        return m[2];
    endfunction

endpackage

// File: rtl/trig_dma_sync.sv
// Trigger conditioner: a STAGES-deep synchronizer followed by a rising-edge
// detector. Assumes async_in is an unrelated asynchronous signal.
module trig_dma_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [STAGES:0] sh_q;

    // Shift the trigger through the synchronizer plus one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], async_in};
    end

    assign level = sh_q[STAGES-1];
    assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/trig_dma_addr.sv
// Working address register for one side of the channel. Loads the programmed
// base on load, otherwise moves by the step code on adv. Assumes load and adv
// are never both needed in one cycle (load wins).
module trig_dma_addr
    import trig_dma_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic [AW-1:0] base,
    input  logic [1:0]    step,
    input  logic          word,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] inc;

    assign inc = word ? AW'(2) : AW'(1);

    // Hold, reload or step the working address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= base;
        end else if (adv) begin
            case (step)
                STEP_DEC: addr <= addr - inc;
                STEP_INC: addr <= addr + inc;
                default:  addr <= addr;
            endcase
        end
    end
endmodule

// File: rtl/trig_dma_ctrl.sv
// Sequencer for one channel: arming, trigger acceptance, the read/write/idle
// transfer pattern, burst gaps, completion, stop requests and flags.
// Assumes wsize_zero/wsize_last describe the working count of the datapath.
module trig_dma_ctrl
    import trig_dma_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int GAP_LEN   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       level_mode,
    input  logic       abort_en,
    input  logic       en_set,
    input  logic       en_clr,
    input  logic       sw_req,
    input  logic       flag_clr,
    input  logic       nmi,
    input  logic       trig_lvl,
    input  logic       trig_rise,
    input  logic       wsize_zero,
    input  logic       wsize_last,
    output dma_state_e st,
    output logic       load,
    output logic       adv,
    output logic       halt,
    output logic       en,
    output logic       irq,
    output logic       abort
);
    localparam int BCW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam int GCW = (GAP_LEN > 1) ? $clog2(GAP_LEN) : 1;

    logic           blk_q, swreq_q, kill_q, abt_q;
    logic [BCW-1:0] bcnt;
    logic [GCW-1:0] gcnt;
    logic           single, burst, rep;
    logic           abort_hit, stop_now, stall, can_go;

    assign single    = mode_single(mode);
    assign burst     = mode_burst(mode);
    assign rep       = mode_repeat(mode);
    assign abort_hit = abt_q | (nmi & abort_en);
    assign stop_now  = kill_q | en_clr | abort_hit;
    assign stall     = level_mode & ~trig_lvl;
    assign can_go    = blk_q ? ~stall
                             : (swreq_q | (level_mode ? trig_lvl : trig_rise));

    // Working-register load at arming or completion; step after a write
    assign load = ((st == ST_IDLE) & en_set) | ((st == ST_WR) & wsize_last);
    assign adv  = (st == ST_WR) & ~wsize_last;

    // CPU halt during transfers and across a running block unless paused
    assign halt = (st == ST_RD) | (st == ST_WR) |
                  ((st == ST_IDLE) & blk_q & en & ~stall & ~stop_now);

    // Main sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            en      <= 1'b0;
            blk_q   <= 1'b0;
            swreq_q <= 1'b0;
            kill_q  <= 1'b0;
            abt_q   <= 1'b0;
            irq     <= 1'b0;
            abort   <= 1'b0;
            bcnt    <= '0;
            gcnt    <= '0;
        end else begin
            if (sw_req && !blk_q) swreq_q <= 1'b1;
            if (en && st != ST_IDLE) begin
                if (en_clr)            kill_q <= 1'b1;
                if (nmi && abort_en)   abt_q  <= 1'b1;
            end
            if (flag_clr) begin
                irq   <= 1'b0;
                abort <= 1'b0;
            end
            case (st)
                ST_IDLE: begin
                    if (en_set) begin
                        en      <= 1'b1;
                        blk_q   <= 1'b0;
                        bcnt    <= '0;
                        kill_q  <= 1'b0;
                        abt_q   <= 1'b0;
                        swreq_q <= 1'b0;
                    end else if (en && stop_now) begin
                        en     <= 1'b0;
                        blk_q  <= 1'b0;
                        kill_q <= 1'b0;
                        abt_q  <= 1'b0;
                        if (abort_hit) abort <= 1'b1;
                    end else if (en && !wsize_zero && can_go) begin
                        st <= ST_RD;
                        if (!blk_q) begin
                            swreq_q <= 1'b0;
                            if (!single) begin
                                blk_q <= 1'b1;
                                bcnt  <= '0;
                            end
                        end
                    end
                end
                ST_RD: st <= ST_WR;
                ST_WR: begin
                    if (wsize_last) begin
                        irq  <= 1'b1;
                        bcnt <= '0;
                        st   <= ST_IDLE;
                        if (!rep) begin
                            en    <= 1'b0;
                            blk_q <= 1'b0;
                        end else if (!burst) begin
                            blk_q <= 1'b0;
                        end
                    end else if (burst && bcnt == BCW'(BURST_LEN - 1)) begin
                        bcnt <= '0;
                        gcnt <= '0;
                        st   <= ST_GAP;
                    end else begin
                        if (burst) bcnt <= bcnt + 1'b1;
                        st <= ST_IDLE;
                    end
                end
                ST_GAP: begin
                    gcnt <= gcnt + 1'b1;
                    if (gcnt == GCW'(GAP_LEN - 1)) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/trig_dma_channel.sv
// Top of one triggered DMA channel: trigger conditioning, sequencer, two
// working address generators, the working count and the width-converting
// data path. Assumes mem_rdata is valid the cycle after mem_rd.
module trig_dma_channel
    import trig_dma_pkg::*;
#(
    parameter int AW          = 16,
    parameter int SW          = 16,
    parameter int SYNC_STAGES = 2,
    parameter int BURST_LEN   = 4,
    parameter int GAP_LEN     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    cfg_mode,
    input  logic [1:0]    cfg_src_step,
    input  logic [1:0]    cfg_dst_step,
    input  logic          cfg_src_word,
    input  logic          cfg_dst_word,
    input  logic          cfg_level,
    input  logic          cfg_abort_en,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [SW-1:0] cfg_size,
    input  logic          en_set,
    input  logic          en_clr,
    input  logic          sw_req,
    input  logic          flag_clr,
    input  logic          trig_in,
    input  logic          nmi,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          mem_word,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata,
    output logic          cpu_halt,
    output logic          chan_en,
    output logic          irq_flag,
    output logic          abort_flag
);
    localparam int NSIDE = 2;

    dma_state_e    st;
    logic          trig_lvl, trig_rise, load, adv;
    logic [SW-1:0] wsize;
    logic          wsize_zero, wsize_last;
    logic [AW-1:0] base_a [NSIDE];
    logic [1:0]    step_a [NSIDE];
    logic          word_a [NSIDE];
    logic [AW-1:0] addr_a [NSIDE];

    trig_dma_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(trig_in),
        .level(trig_lvl), .rise(trig_rise)
    );

    trig_dma_ctrl #(.BURST_LEN(BURST_LEN), .GAP_LEN(GAP_LEN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .level_mode(cfg_level),
        .abort_en(cfg_abort_en), .en_set(en_set), .en_clr(en_clr),
        .sw_req(sw_req), .flag_clr(flag_clr), .nmi(nmi),
        .trig_lvl(trig_lvl), .trig_rise(trig_rise),
        .wsize_zero(wsize_zero), .wsize_last(wsize_last),
        .st(st), .load(load), .adv(adv), .halt(cpu_halt),
        .en(chan_en), .irq(irq_flag), .abort(abort_flag)
    );

    assign base_a[0] = cfg_src;
    assign base_a[1] = cfg_dst;
    assign step_a[0] = cfg_src_step;
    assign step_a[1] = cfg_dst_step;
    assign word_a[0] = cfg_src_word;
    assign word_a[1] = cfg_dst_word;

    generate
        for (genvar k = 0; k < NSIDE; k++) begin : g_side
            trig_dma_addr #(.AW(AW)) u_addr (
                .clk(clk), .rst_n(rst_n), .load(load), .adv(adv),
                .base(base_a[k]), .step(step_a[k]), .word(word_a[k]),
                .addr(addr_a[k])
            );
        end
    endgenerate

    // Working transfer count: load, then count down one per write
    always_ff @(posedge clk) begin
        if (!rst_n)    wsize <= '0;
        else if (load) wsize <= cfg_size;
        else if (adv)  wsize <= wsize - 1'b1;
    end

    assign wsize_zero = (wsize == '0);
    assign wsize_last = (wsize == SW'(1));

    assign mem_rd    = (st == ST_RD);
    assign mem_wr    = (st == ST_WR);
    assign mem_word  = mem_rd ? cfg_src_word : cfg_dst_word;
    assign mem_addr  = mem_rd ? addr_a[0] : addr_a[1];
    assign mem_wdata = (cfg_src_word & cfg_dst_word) ? mem_rdata
                     : {{(WORD_W - BYTE_W){1'b0}}, mem_rdata[BYTE_W-1:0]};
endmodule

// File: rtl/trig_dma_channel_chk.sv
// Protocol checker for the triggered DMA channel, bound to the top module.
module trig_dma_channel_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          mem_word,
    input logic [AW-1:0] mem_addr,
    input logic [15:0]   mem_wdata,
    input logic          cpu_halt,
    input logic          chan_en,
    input logic          irq_flag,
    input logic          abort_flag,
    input logic          flag_clr
);
    // R10: a read is always followed by its write
    p_rd_then_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_wr);

    // R10: a write is followed by a cycle with no strobe
    p_wr_then_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (!mem_rd && !mem_wr));

    // R10: never both strobes at once
    p_excl_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R6: CPU is halted while the bus is in use
    p_halt_in_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> cpu_halt);

    // R2: no read happens on a disarmed channel
    p_rd_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> chan_en);

    // R3: the completion flag is sticky until cleared
    p_irq_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !flag_clr) |=> irq_flag);

    // R8: byte read written as a word carries a zero upper byte
    p_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_word && !$past(mem_word)) |-> (mem_wdata[15:8] == 8'h00));

    // R11: when the abort flag rises the channel is disarmed and idle
    p_abort_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_flag) |-> (!chan_en && !mem_rd && !cpu_halt));
endmodule

bind trig_dma_channel trig_dma_channel_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_word(mem_word), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cpu_halt(cpu_halt), .chan_en(chan_en), .irq_flag(irq_flag),
    .abort_flag(abort_flag), .flag_clr(flag_clr)
);

// File: tb/trig_dma_channel_tb.sv
`timescale 1ns/1ps
module trig_dma_channel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_mode = '0;
    logic [1:0]  cfg_src_step = '0, cfg_dst_step = '0;
    logic        cfg_src_word = 1'b0, cfg_dst_word = 1'b0;
    logic        cfg_level = 1'b0, cfg_abort_en = 1'b0;
    logic [15:0] cfg_src = '0, cfg_dst = '0, cfg_size = '0;
    logic        en_set = 1'b0, en_clr = 1'b0, sw_req = 1'b0, flag_clr = 1'b0;
    logic        trig_in = 1'b0, nmi = 1'b0;
    logic        mem_rd, mem_wr, mem_word;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        cpu_halt, chan_en, irq_flag, abort_flag;

    int checks = 0, errors = 0;
    bit done = 0;
    int cyc = 0;
    int rdn = 0, wrn = 0;
    logic [15:0] rd_a [0:1023];
    logic [15:0] wr_a [0:1023];
    logic [15:0] wr_d [0:1023];
    logic        wr_w [0:1023];
    int          wr_t [0:1023];

    always #2.5 clk = ~clk;

    trig_dma_channel u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
        .cfg_src_step(cfg_src_step), .cfg_dst_step(cfg_dst_step),
        .cfg_src_word(cfg_src_word), .cfg_dst_word(cfg_dst_word),
        .cfg_level(cfg_level), .cfg_abort_en(cfg_abort_en),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_size(cfg_size),
        .en_set(en_set), .en_clr(en_clr), .sw_req(sw_req), .flag_clr(flag_clr),
        .trig_in(trig_in), .nmi(nmi), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_word(mem_word), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .cpu_halt(cpu_halt), .chan_en(chan_en),
        .irq_flag(irq_flag), .abort_flag(abort_flag)
    );

    // Memory content model: word reads and byte reads (junk upper lane)
    function automatic logic [15:0] model(input logic [15:0] a, input logic w);
        return w ? ((a ^ 16'hA55A) + 16'h1234) : {8'hEE, a[7:0] ^ 8'h5A};
    endfunction

    // Address of the i-th access from a base under a step code
    function automatic logic [15:0] addr_at(input logic [15:0] b, input logic [1:0] s,
                                            input logic w, input int i);
        int inc = w ? 2 : 1;
        case (s)
            2'b10:   return b - 16'(i * inc);
            2'b11:   return b + 16'(i * inc);
            default: return b;
        endcase
    endfunction

    // Synchronous memory: data valid the cycle after the read strobe
    always @(posedge clk) if (mem_rd) mem_rdata <= model(mem_addr, mem_word);

    // Bus monitor
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (mem_rd) begin
                if (rdn < 1024) rd_a[rdn] = mem_addr;
                rdn++;
            end
            if (mem_wr) begin
                if (wrn < 1024) begin
                    wr_a[wrn] = mem_addr; wr_d[wrn] = mem_wdata;
                    wr_w[wrn] = mem_word; wr_t[wrn] = cyc;
                end
                wrn++;
            end
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input logic [2:0] m, input logic [1:0] ss, input logic sw,
                         input logic [1:0] ds, input logic dw, input logic [15:0] s,
                         input logic [15:0] d, input logic [15:0] n, input logic lv,
                         input logic ab);
        @(negedge clk);
        cfg_mode = m; cfg_src_step = ss; cfg_src_word = sw; cfg_dst_step = ds;
        cfg_dst_word = dw; cfg_src = s; cfg_dst = d; cfg_size = n;
        cfg_level = lv; cfg_abort_en = ab;
    endtask

    task automatic pulse_en();   en_set = 1;   @(negedge clk); en_set = 0;   endtask
    task automatic pulse_clr();  en_clr = 1;   @(negedge clk); en_clr = 0;   endtask
    task automatic pulse_sw();   sw_req = 1;   @(negedge clk); sw_req = 0;   endtask
    task automatic pulse_flag(); flag_clr = 1; @(negedge clk); flag_clr = 0; endtask
    task automatic edge_trig();  trig_in = 1; tick(8); trig_in = 0; tick(3); endtask

    task automatic wait_off(input int maxc);
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (!chan_en) break;
        end
        tick(2);
    endtask

    // Compare n logged transfers against the bench model
    task automatic check_xfers(input string tag, input int rb, input int wb, input int n,
                               input int ofs);
        for (int i = 0; i < n; i++) begin
            logic [15:0] sa, da, d, e;
            sa = addr_at(cfg_src, cfg_src_step, cfg_src_word, i + ofs);
            da = addr_at(cfg_dst, cfg_dst_step, cfg_dst_word, i + ofs);
            d  = model(sa, cfg_src_word);
            e  = (cfg_src_word && cfg_dst_word) ? d : {8'h00, d[7:0]};
            chk({tag, " R7 src addr"}, rd_a[rb + i], sa);
            chk({tag, " R7 dst addr"}, wr_a[wb + i], da);
            chk({tag, " R8 data"}, wr_d[wb + i], e);
            chk({tag, " R8 width"}, 32'(wr_w[wb + i]), 32'(cfg_dst_word));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int rb, wb, c1, lowc, seen;
        bit started;
        void'($urandom(32'd20240611));
        tick(4);
        rst_n = 1;
        tick(1);
        // R12: reset state
        chk("R12 chan_en", 32'(chan_en), 0);
        chk("R12 cpu_halt", 32'(cpu_halt), 0);
        chk("R12 irq_flag", 32'(irq_flag), 0);
        chk("R12 abort_flag", 32'(abort_flag), 0);
        chk("R12 strobes", 32'(mem_rd | mem_wr), 0);

        // Block, word to word, increment: R2 R3 R5 R10 R1
        setup(3'b001, 2'b11, 1, 2'b11, 1, 16'h1000, 16'h2000, 16'd5, 0, 0);
        rb = rdn; wb = wrn;
        pulse_en(); edge_trig(); wait_off(200);
        chk("R5 block count", 32'(wrn - wb), 5);
        check_xfers("blk", rb, wb, 5, 0);
        for (int i = 0; i < 4; i++) chk("R10 spacing", 32'(wr_t[wb+i+1] - wr_t[wb+i]), 3);
        chk("R3 irq set", 32'(irq_flag), 1);
        chk("R1 block clears en", 32'(chan_en), 0);
        pulse_flag();
        chk("R3 irq cleared", 32'(irq_flag), 0);

        // Single mode, byte inc to word dec: R4 R8 R7
        setup(3'b000, 2'b11, 0, 2'b10, 1, 16'h0100, 16'h0220, 16'd3, 0, 0);
        rb = rdn; wb = wrn;
        pulse_en();
        trig_in = 1; tick(12); trig_in = 0; tick(4);
        chk("R4 held edge one xfer", 32'(wrn - wb), 1);
        pulse_sw(); tick(10);
        chk("R4 sw one xfer", 32'(wrn - wb), 2);
        chk("R1 single en kept mid", 32'(chan_en), 1);
        pulse_sw(); tick(10);
        chk("R4 third xfer", 32'(wrn - wb), 3);
        check_xfers("single", rb, wb, 3, 0);
        chk("R1 single clears en", 32'(chan_en), 0);
        chk("R3 single irq", 32'(irq_flag), 1);
        pulse_flag();

        // Zero size: R2
        setup(3'b001, 2'b11, 0, 2'b11, 0, 16'h3000, 16'h4000, 16'd0, 0, 0);
        wb = wrn;
        pulse_en(); pulse_sw(); edge_trig(); tick(20);
        chk("R2 zero size no xfer", 32'(wrn - wb), 0);
        chk("R2 zero size no irq", 32'(irq_flag), 0);
        pulse_clr(); tick(3);

        // Burst-block halt gaps: R6
        setup(3'b010, 2'b11, 1, 2'b11, 1, 16'h5000, 16'h6000, 16'd10, 0, 0);
        rb = rdn; wb = wrn;
        pulse_en(); sw_req = 1;
        started = 0; lowc = 0; seen = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            sw_req = 0;
            if (mem_rd) started = 1;
            if (started && seen < 10 && !cpu_halt) lowc++;
            if (mem_wr) seen++;
            if (!chan_en && seen > 0) break;
        end
        tick(2);
        chk("R6 burst halt low cycles", 32'(lowc), 4);
        chk("R6 halt released at end", 32'(cpu_halt), 0);
        check_xfers("burst", rb, wb, 10, 0);
        pulse_flag();

        // Repeated block, word hold to byte dec, triggers ignored: R5 R3 R1 R8
        setup(3'b101, 2'b01, 1, 2'b10, 0, 16'h7000, 16'h8010, 16'd4, 0, 0);
        rb = rdn; wb = wrn;
        pulse_en(); pulse_sw();
        for (int i = 0; i < 100; i++) begin
            @(posedge clk);
            if (wrn - wb >= 2) break;
        end
        @(negedge clk);
        sw_req = 1; trig_in = 1; @(negedge clk); sw_req = 0; tick(6); trig_in = 0;
        tick(40);
        chk("R5 extra triggers ignored", 32'(wrn - wb), 4);
        chk("R1 repeated block keeps en", 32'(chan_en), 1);
        edge_trig(); tick(30);
        chk("R5 repeated block needs trigger", 32'(wrn - wb), 8);
        check_xfers("rblk1", rb, wb, 4, 0);
        check_xfers("R3 reload", rb + 4, wb + 4, 4, 0);
        pulse_clr(); tick(3);
        pulse_flag();

        // Repeated burst restarts alone, en_clr stops it: R5 R11
        setup(3'b110, 2'b11, 0, 2'b11, 0, 16'h0A00, 16'h0B00, 16'd3, 0, 0);
        rb = rdn; wb = wrn;
        pulse_en(); pulse_sw(); tick(40);
        chk("R5 repeated burst restarts", 32'((wrn - wb) >= 6), 1);
        chk("R1 repeated burst en", 32'(chan_en), 1);
        check_xfers("rburst1", rb, wb, 3, 0);
        check_xfers("rburst2", rb + 3, wb + 3, 3, 0);
        pulse_clr(); tick(10);
        c1 = wrn;
        tick(20);
        chk("R11 en_clr stops", 32'(wrn), 32'(c1));
        chk("R11 en_clr disarms", 32'(chan_en), 0);
        chk("R11 en_clr no abort flag", 32'(abort_flag), 0);
        pulse_flag();

        // Level trigger stall and resume: R9
        setup(3'b001, 2'b11, 0, 2'b11, 0, 16'h0C00, 16'h0D00, 16'd6, 1, 0);
        rb = rdn; wb = wrn;
        pulse_en(); trig_in = 1;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk);
            if (wrn - wb >= 2) break;
        end
        @(negedge clk); trig_in = 0;
        tick(12);
        c1 = wrn - wb;
        chk("R9 stalled before end", 32'(c1 < 6), 1);
        chk("R9 halt low while stalled", 32'(cpu_halt), 0);
        tick(15);
        chk("R9 no progress while low", 32'(wrn - wb), 32'(c1));
        trig_in = 1; wait_off(200); trig_in = 0;
        chk("R9 resumed total", 32'(wrn - wb), 6);
        check_xfers("level", rb, wb, 6, 0);
        pulse_flag();

        // NMI abort lets the in-flight write finish: R11
        setup(3'b001, 2'b11, 1, 2'b11, 1, 16'h0E00, 16'h0F00, 16'd8, 0, 1);
        rb = rdn; wb = wrn;
        pulse_en(); pulse_sw();
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (mem_rd) seen++;
            if (seen == 3) break;
        end
        nmi = 1; @(negedge clk); nmi = 0;
        tick(6);
        chk("R11 in-flight write done", 32'(wrn - wb), 3);
        chk("R11 abort flag", 32'(abort_flag), 1);
        chk("R11 disarmed", 32'(chan_en), 0);
        chk("R11 halt released", 32'(cpu_halt), 0);
        check_xfers("nmi", rb, wb, 3, 0);
        pulse_flag();
        chk("R11 abort flag cleared", 32'(abort_flag), 0);

        // Seeded random block / burst configurations: R7 R8 R5
        for (int it = 0; it < 20; it++) begin
            logic [2:0] m;
            logic [15:0] n;
            m = 3'($urandom_range(3, 1));
            n = 16'($urandom_range(6, 1));
            setup(m, 2'($urandom_range(3, 0)), 1'($urandom_range(1, 0)),
                  2'($urandom_range(3, 0)), 1'($urandom_range(1, 0)),
                  16'($urandom), 16'($urandom), n, 0, 0);
            rb = rdn; wb = wrn;
            pulse_en(); pulse_sw(); wait_off(300);
            chk("R5 random count", 32'(wrn - wb), 32'(n));
            check_xfers("rand", rb, wb, int'(n), 0);
            pulse_flag();
        end

        summary();
    end
endmodule